// File: doc/BRIEF.md
# Single-Wire Search Triplet Engine

This block carries out one step of the binary-tree address search used to find every device on a single-wire bus. A search controller pulses `start_i` with a preferred branch bit. The engine then asks a bit time-slot generator for two read slots. The first read returns the address bit of all devices still in the search, and the second returns its complement. From this pair the engine picks a branch and asks for one write slot that sends the branch bit onto the bus. It then reports a 3-bit status with a one-cycle done strobe.

The controller keeps the 64-bit address and the discrepancy bookkeeping; this block does not. The engine talks to the slot generator through a request that is held until the generator answers. The request says whether the slot is a read or a write and which bit a write sends. The answer is a one-cycle acknowledge that carries the level sampled on the bus. When both reads return 1, no device answered. In that case the step ends early with an error status and no write slot, so the controller knows the search must start again.

Top module: `onewire_triplet`

## Requirements
- R1: After reset the engine is idle: `status_o` is 3'b000, `done_o` is 0 and `slot_req_o` is 0.
- R2: The cycle after an accepted start, the engine requests a read slot (`slot_wr_o`=0). After that slot is acknowledged it requests a second read slot. The first read bit lands in status bit 0 (id bit) and the second in status bit 1 (complement bit).
- R3: When both reads return 1, the status becomes 3'b011, no write slot is requested, and done follows in the cycle after the second read is acknowledged.
- R4: When both reads return 0, the direction taken is the preferred bit that was sampled together with the accepted start. The status is 3'b100 for direction 1 and 3'b000 for direction 0.
- R5: When exactly one read returns 1, the direction is forced to the id bit. The status is 3'b101 when the id bit is 1 and 3'b010 when the complement bit is 1.
- R6: Outside the error case, a single write slot (`slot_wr_o`=1) follows the two reads, and `slot_wbit_o` carries the chosen direction. Status bit 2 reports that same direction.
- R7: A slot request stays asserted with unchanged `slot_wr_o` and `slot_wbit_o` until `slot_ack_i` is seen high. Acknowledges that arrive while no request is pending have no effect.
- R8: `done_o` is high for exactly one cycle: the cycle after the acknowledge of the last slot of the step.
- R9: `status_o` changes only in the cycle `done_o` rises and holds its value between steps.
- R10: A start pulse, or a change of the preferred bit, while a step is in progress has no effect on that step and does not begin a new one.
- R11: During a read slot request, `slot_wbit_o` holds the parameter `WBIT_IDLE` (default 1, line released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one search step (taken only when idle) |
| dir_pref_i | input | 1 | Preferred branch when both reads return 0 |
| status_o | output | 3 | {direction taken, complement bit, id bit} |
| done_o | output | 1 | One-cycle completion strobe |
| slot_req_o | output | 1 | Slot request to the bit time-slot generator |
| slot_wr_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit sent in a write slot |
| slot_ack_i | input | 1 | One-cycle slot completion from the generator |
| slot_rbit_i | input | 1 | Bus level sampled in the acknowledged slot |

## Verification
The bench builds the engine with the default `WBIT_IDLE` of 1. So the read-slot value of `slot_wbit_o` is compared against a released line on every cycle, and the write slots are easy to tell apart from the reads. The slot responder in the bench answers with acknowledge delays from zero to several cycles. This covers both back-to-back slots and long-held requests. The bench also injects stray acknowledges while idle and start pulses in the middle of a step. All four read-pair combinations are run with both preferred bits.

// File: rtl/triplet_pkg.sv
package triplet_pkg;

  localparam int unsigned STAT_W = 3;
  localparam int unsigned ST_ID  = 0;
  localparam int unsigned ST_CMP = 1;
  localparam int unsigned ST_DIR = 2;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RID  = 3'd1,
    PH_RCMP = 3'd2,
    PH_WDIR = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;

  // Branch choice: a lone 1 forces the id bit, an all-zero pair takes the preference.
  function automatic logic pick_dir(input logic idb, input logic cmpb, input logic pref);
    if (idb ^ cmpb) return idb;
    return pref;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic dir, input logic cmpb,
                                                    input logic idb);
    logic [STAT_W-1:0] s;
    s         = '0;
    s[ST_ID]  = idb;
    s[ST_CMP] = cmpb;
    s[ST_DIR] = dir;
    return s;
  endfunction

  function automatic logic [STAT_W-1:0] abort_status();
    return pack_status(1'b0, 1'b1, 1'b1);
  endfunction

endpackage

// File: rtl/trp_seq.sv
module trp_seq
  import triplet_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   ack_i,
  input  logic   abort_i,
  output phase_t phase_o,
  output logic   busy_o,
  output logic   take_o,
  output logic   evt_id_o,
  output logic   evt_cmp_o,
  output logic   evt_wr_o,
  output logic   fin_o
);

  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) ph_d = PH_RID;
      PH_RID:  if (ack_i)   ph_d = PH_RCMP;
      PH_RCMP: if (ack_i)   ph_d = abort_i ? PH_FIN : PH_WDIR;
      PH_WDIR: if (ack_i)   ph_d = PH_FIN;
      PH_FIN:               ph_d = PH_IDLE;
      default:              ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase_o   = ph_q;
  assign busy_o    = (ph_q != PH_IDLE);
  assign take_o    = (ph_q == PH_IDLE) && start_i;
  assign evt_id_o  = (ph_q == PH_RID)  && ack_i;
  assign evt_cmp_o = (ph_q == PH_RCMP) && ack_i;
  assign evt_wr_o  = (ph_q == PH_WDIR) && ack_i;
  assign fin_o     = (ph_q == PH_FIN);

endmodule

// File: rtl/trp_verdict.sv
module trp_verdict
  import triplet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              pref_i,
  input  logic              rbit_i,
  input  logic              evt_id_i,
  input  logic              evt_cmp_i,
  input  logic              evt_wr_i,
  output logic              abort_o,
  output logic              dir_o,
  output logic              pref_q_o,
  output logic [STAT_W-1:0] status_o
);

  logic              pref_q, id_q, cmp_q, dir_q;
  logic [STAT_W-1:0] stat_q;

  assign abort_o = id_q & rbit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_q <= 1'b0;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      dir_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (take_i)   pref_q <= pref_i;
      if (evt_id_i) id_q   <= rbit_i;
      if (evt_cmp_i) begin
        cmp_q <= rbit_i;
        dir_q <= pick_dir(id_q, rbit_i, pref_q);
        if (abort_o) stat_q <= abort_status();
      end
      if (evt_wr_i) stat_q <= pack_status(dir_q, cmp_q, id_q);
    end
  end

  assign dir_o    = dir_q;
  assign pref_q_o = pref_q;
  assign status_o = stat_q;

endmodule

// File: rtl/trp_slot_drv.sv
module trp_slot_drv
  import triplet_pkg::*;
#(
  parameter bit WBIT_IDLE = 1'b1
) (
  input  phase_t phase_i,
  input  logic   dir_i,
  output logic   req_o,
  output logic   wr_o,
  output logic   wbit_o
);

  logic rd_slot;

  assign rd_slot = (phase_i == PH_RID) || (phase_i == PH_RCMP);
  assign wr_o    = (phase_i == PH_WDIR);
  assign req_o   = rd_slot || wr_o;

  generate
    if (WBIT_IDLE) begin : g_rel_hi
      assign wbit_o = wr_o ? dir_i : 1'b1;
    end else begin : g_rel_lo
      assign wbit_o = wr_o & dir_i;
    end
  endgenerate

endmodule

// File: rtl/onewire_triplet.sv
module onewire_triplet
  import triplet_pkg::*;
#(
  parameter bit WBIT_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_pref_i,
  output logic [STAT_W-1:0] status_o,
  output logic              done_o,
  output logic              slot_req_o,
  output logic              slot_wr_o,
  output logic              slot_wbit_o,
  input  logic              slot_ack_i,
  input  logic              slot_rbit_i
);

  phase_t phase;
  logic   busy, take, evt_id, evt_cmp, evt_wr, fin, abort_now, dir_sel, pref_held;

  trp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ack_i    (slot_ack_i),
    .abort_i  (abort_now),
    .phase_o  (phase),
    .busy_o   (busy),
    .take_o   (take),
    .evt_id_o (evt_id),
    .evt_cmp_o(evt_cmp),
    .evt_wr_o (evt_wr),
    .fin_o    (fin)
  );

  trp_verdict u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .pref_i   (dir_pref_i),
    .rbit_i   (slot_rbit_i),
    .evt_id_i (evt_id),
    .evt_cmp_i(evt_cmp),
    .evt_wr_i (evt_wr),
    .abort_o  (abort_now),
    .dir_o    (dir_sel),
    .pref_q_o (pref_held),
    .status_o (status_o)
  );

  trp_slot_drv #(.WBIT_IDLE(WBIT_IDLE)) u_drv (
    .phase_i(phase),
    .dir_i  (dir_sel),
    .req_o  (slot_req_o),
    .wr_o   (slot_wr_o),
    .wbit_o (slot_wbit_o)
  );

  assign done_o = fin;

endmodule

// File: rtl/onewire_triplet_chk.sv
module onewire_triplet_chk
  import triplet_pkg::*;
#(
  parameter bit WBIT_IDLE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [STAT_W-1:0] status_o,
  input logic              done_o,
  input logic              slot_req_o,
  input logic              slot_wr_o,
  input logic              slot_wbit_o,
  input logic              slot_ack_i,
  input logic              slot_rbit_i,
  input logic              busy,
  input logic              evt_cmp,
  input logic              abort_now,
  input logic              pref_held
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_wr_o) && $stable(slot_wbit_o)));

  a_r3_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmp && abort_now) |=> (done_o && !slot_req_o && status_o == 3'b011));

  a_r6_dir_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && slot_wr_o && slot_ack_i) |=> (done_o && status_o[ST_DIR] == $past(slot_wbit_o)));

  a_r5_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o != 3'b111 && status_o != 3'b110 && status_o != 3'b001));

  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(status_o)));

  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(pref_held));

  a_r11_read_wbit: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_wr_o) |-> (slot_wbit_o == WBIT_IDLE));

  logic unused_rbit;
  assign unused_rbit = slot_rbit_i;

endmodule

bind onewire_triplet onewire_triplet_chk #(.WBIT_IDLE(WBIT_IDLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .status_o   (status_o),
  .done_o     (done_o),
  .slot_req_o (slot_req_o),
  .slot_wr_o  (slot_wr_o),
  .slot_wbit_o(slot_wbit_o),
  .slot_ack_i (slot_ack_i),
  .slot_rbit_i(slot_rbit_i),
  .busy       (busy),
  .evt_cmp    (evt_cmp),
  .abort_now  (abort_now),
  .pref_held  (pref_held)
);

// File: tb/sim_onewire_triplet.sv
`timescale 1ns/1ps
module sim_onewire_triplet;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, dir_pref_i = 1'b0;
  logic       slot_ack_i = 1'b0, slot_rbit_i = 1'b0;
  logic [2:0] status_o;
  logic       done_o, slot_req_o, slot_wr_o, slot_wbit_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  onewire_triplet u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_pref_i(dir_pref_i),
    .status_o(status_o), .done_o(done_o), .slot_req_o(slot_req_o),
    .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o),
    .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i)
  );

  // Behavioural reference: step number (0 idle, 1 first read, 2 second read, 3 write, 4 done)
  int         m_step = 0;
  bit         m_pref, m_id, m_cmp, m_dir;
  logic [2:0] m_stat = 3'b000;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step <= 0; m_stat <= 3'b000;
    end else begin
      case (m_step)
        0: if (start_i) begin m_step <= 1; m_pref <= dir_pref_i; end
        1: if (slot_ack_i) begin m_id <= slot_rbit_i; m_step <= 2; end
        2: if (slot_ack_i) begin
             m_cmp <= slot_rbit_i;
             if (m_id && slot_rbit_i) begin m_stat <= 3'b011; m_step <= 4; end
             else begin
               m_dir  <= (m_id != slot_rbit_i) ? m_id : m_pref;
               m_step <= 3;
             end
           end
        3: if (slot_ack_i) begin m_stat <= {m_dir, m_cmp, m_id}; m_step <= 4; end
        default: m_step <= 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(slot_req_o == (m_step >= 1 && m_step <= 3), "R7 request", slot_req_o, (m_step >= 1 && m_step <= 3));
      check(done_o == (m_step == 4), "R8 done", done_o, m_step == 4);
      check(status_o == m_stat, "R9 status", status_o, m_stat);
      if (slot_req_o) begin
        check(slot_wr_o == (m_step == 3), "R2 slot kind", slot_wr_o, m_step == 3);
        check(slot_wbit_o == ((m_step == 3) ? m_dir : 1'b1), "R11/R6 wbit", slot_wbit_o,
              (m_step == 3) ? m_dir : 1'b1);
      end
    end
  end

  function automatic logic [2:0] want(input bit p, input bit a, input bit b);
    if (a && b) return 3'b011;
    if (a && !b) return 3'b101;
    if (!a && b) return 3'b010;
    return {p, 2'b00};
  endfunction

  task automatic answer(input bit v, input int lat, input bit want_wr, input string req);
    int guard = 0;
    while (!slot_req_o && guard < 20) begin @(negedge clk); guard++; end
    check(slot_req_o && slot_wr_o == want_wr, req, slot_wr_o, want_wr);
    for (int k = 0; k < lat; k++) @(negedge clk);
    slot_ack_i = 1'b1; slot_rbit_i = v;
    @(negedge clk);
    slot_ack_i = 1'b0; slot_rbit_i = 1'b0;
  endtask

  task automatic step(input bit p, input bit a, input bit b, input int lat, input bit poke);
    logic [2:0] e;
    e = want(p, a, b);
    @(negedge clk); start_i = 1'b1; dir_pref_i = p;
    @(negedge clk); start_i = 1'b0;
    answer(a, lat, 1'b0, "R2 first read");
    if (poke) begin start_i = 1'b1; dir_pref_i = ~p; end
    answer(b, lat, 1'b0, "R2 second read");
    start_i = 1'b0;
    if (!(a && b)) begin
      check(slot_wbit_o == e[2], "R6 write bit", slot_wbit_o, e[2]);
      answer(1'b0, lat, 1'b1, "R6 write slot");
    end else begin
      check(!slot_req_o, "R3 no write slot", slot_req_o, 0);
    end
    check(done_o == 1'b1, "R8 done after last slot", done_o, 1);
    if (a && b)        check(status_o == e, "R3 abort status", status_o, e);
    else if (a == b)   check(status_o == e, "R4 preferred status", status_o, e);
    else               check(status_o == e, "R5 forced status", status_o, e);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single", done_o, 0);
    check(!slot_req_o, "R10 no restart", slot_req_o, 0);
    check(status_o == e, "R9 status held", status_o, e);
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status_o == 3'b000, "R1 reset status", status_o, 0);
    check(!done_o && !slot_req_o, "R1 reset idle", {done_o, slot_req_o}, 0);
    rst_n = 1'b1;
    // stray acknowledge while idle
    @(negedge clk); slot_ack_i = 1'b1; slot_rbit_i = 1'b1;
    @(negedge clk); slot_ack_i = 1'b0; slot_rbit_i = 1'b0;
    check(!slot_req_o && status_o == 3'b000, "R7 stray ack ignored", status_o, 0);
    for (int lat = 0; lat < 3; lat++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            step(p[0], a[0], b[0], lat, 1'b0);
    // starts and preference flips mid-step
    step(1'b1, 1'b0, 1'b0, 1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 0, 1'b1);
    step(1'b0, 1'b1, 1'b1, 2, 1'b1);
    step(1'b1, 1'b0, 1'b1, 4, 1'b1);
    repeat (5) @(negedge clk);
    check(status_o == 3'b010, "R9 long hold", status_o, 3'b010);
    wrap_up();
  end

endmodule